// File: doc/BRIEF.md
# Shared SRAM Boot-Handoff Controller

This block sits between one SRAM, an external loader and an embedded processor, and decides which of the two may use the memory. The loader issues word writes, word reads, start and halt commands through a user command port. A single run flag decides ownership. While the flag is clear, the loader drives the SRAM address, write data and strobes, and the processor is kept off the memory. While the flag is set, the processor's memory port drives the SRAM.

The processor's boot code polls one check address and waits for bit 1 of the returned word. The block never sends that address to the SRAM. It answers with a status word instead: zero while the run flag is clear, and only the ready bit set once the loader has issued start. This gates the processor's boot loop.

The loader follows a fixed sequence: wait for a ready pulse, load the program, issue start, wait for a done pulse, then read back the results. The ready pulse is raised on the processor's first poll after reset or after a halt. The done pulse is raised when the running processor writes to a designated result address.

Top module: `sram_handoff_ctrl`

## Requirements
- R1: While run is clear, a user write (op code 0) drives the SRAM address, write data, write strobe and data drive enable from the user port, in the same cycle.
- R2: While run is clear, a user read (op code 1) presents the user address to the SRAM with output enable high. The addressed word appears on the user read data, with the read-valid flag high, exactly one cycle later.
- R3: A processor read of the check address while run is clear returns zero and does not go to the SRAM.
- R4: A processor read of the check address while run is set returns a word with only bit READY_BIT (default 1) set.
- R5: A start command (op code 2) sets run at the next clock edge. From then on, processor reads return SRAM data at the processor address, and processor writes reach the SRAM.
- R6: A halt command (op code 3) clears run at the next clock edge, which returns SRAM ownership to the user port.
- R7: While run is clear, processor accesses assert neither the SRAM write strobe nor the data drive enable, and processor reads of any address other than the check address return zero.
- R8: The ready pulse is high for exactly one cycle, in the cycle after the first processor read of the check address following reset or a halt. Later polls raise no pulse until the next halt.
- R9: A processor write to the result address while run is set writes the SRAM and raises the done pulse in the next cycle, for one cycle.
- R10: While run is set, user write and read commands are ignored: they cause no SRAM write and no read-valid, and they leave memory unchanged.
- R11: After reset, run, the ready pulse, the done pulse and read-valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_cmd_valid | input | 1 | User command strobe |
| usr_cmd_op | input | 2 | 0 write, 1 read, 2 start, 3 halt |
| usr_addr | input | ADDR_W | User word address |
| usr_wdata | input | DATA_W | User write data |
| usr_rdata | output | DATA_W | Captured user read data |
| usr_rvalid | output | 1 | User read data valid |
| usr_ready_pulse | output | 1 | Processor reached its poll loop |
| usr_done_pulse | output | 1 | Processor wrote the result address |
| run | output | 1 | Run flag (processor owns SRAM) |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Data returned to processor |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_wdata_en | output | 1 | SRAM data bus drive enable |
| sram_we | output | 1 | SRAM write strobe |
| sram_oe | output | 1 | SRAM output enable |
| sram_rdata | input | DATA_W | SRAM read data (asynchronous) |

## Verification
Every one of the 256 addresses is written with a distinct arithmetic pattern and read back through the user port, so an address bit swap or a dropped data bit shows up as a mismatch. The check address is polled in both run states and a neighbouring ordinary address is read, which separates the synthesized status word from real SRAM contents. Processor writes, and user writes issued in the wrong ownership state, are followed by a user read-back after a halt, which shows whether an access that should be ignored changed memory. Repeated polls and halt/restart cycles tell apart a ready pulse that rearms correctly from one that fires every time or never fires again.

// File: rtl/sram_handoff_pkg.sv
package sram_handoff_pkg;
   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_READ  = 2'd1,
      OP_START = 2'd2,
      OP_HALT  = 2'd3
   } usr_op_e;
endpackage

// File: rtl/hs_run_ctrl.sv
module hs_run_ctrl
   import sram_handoff_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CHECK_ADDR  = 8'hF0,
   parameter logic [ADDR_W-1:0] RESULT_ADDR = 8'hF4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_cmd_valid,
   input  logic [1:0]        usr_cmd_op,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              run,
   output logic              ready_pulse,
   output logic              done_pulse
);
   logic armed;
   logic start_cmd, halt_cmd, poll_hit, result_hit;

   assign start_cmd  = usr_cmd_valid && (usr_cmd_op == OP_START);
   assign halt_cmd   = usr_cmd_valid && (usr_cmd_op == OP_HALT);
   assign poll_hit   = armed && cpu_req && !cpu_we && (cpu_addr == CHECK_ADDR);
   assign result_hit = run && cpu_req && cpu_we && (cpu_addr == RESULT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run         <= 1'b0;
         armed       <= 1'b1;
         ready_pulse <= 1'b0;
         done_pulse  <= 1'b0;
      end else begin
         if (halt_cmd)       run <= 1'b0;
         else if (start_cmd) run <= 1'b1;
         armed       <= halt_cmd | (armed & ~poll_hit);
         ready_pulse <= poll_hit;
         done_pulse  <= result_hit;
      end
   end
endmodule

// File: rtl/hs_port_mux.sv
module hs_port_mux
   import sram_handoff_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int READY_BIT = 1,
   parameter logic [ADDR_W-1:0] CHECK_ADDR = 8'hF0
)(
   input  logic              run,
   input  logic              usr_cmd_valid,
   input  logic [1:0]        usr_cmd_op,
   input  logic [ADDR_W-1:0] usr_addr,
   input  logic [DATA_W-1:0] usr_wdata,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata,
   output logic              sram_wdata_en,
   output logic              sram_we,
   output logic              sram_oe,
   input  logic [DATA_W-1:0] sram_rdata
);
   logic [DATA_W-1:0] status_word;
   logic usr_wr, usr_rd, cpu_chk, cpu_wr, cpu_rd;

   for (genvar b = 0; b < DATA_W; b++) begin : g_status
      if (b == READY_BIT) begin : g_flag
         assign status_word[b] = run;
      end else begin : g_zero
         assign status_word[b] = 1'b0;
      end
   end

   assign usr_wr  = usr_cmd_valid && (usr_cmd_op == OP_WRITE);
   assign usr_rd  = usr_cmd_valid && (usr_cmd_op == OP_READ);
   assign cpu_chk = cpu_req && !cpu_we && (cpu_addr == CHECK_ADDR);
   assign cpu_wr  = cpu_req && cpu_we;
   assign cpu_rd  = cpu_req && !cpu_we && !cpu_chk;

   always_comb begin
      if (run) begin
         sram_addr     = cpu_addr;
         sram_wdata    = cpu_wdata;
         sram_we       = cpu_wr;
         sram_wdata_en = cpu_wr;
         sram_oe       = cpu_rd;
      end else begin
         sram_addr     = usr_addr;
         sram_wdata    = usr_wdata;
         sram_we       = usr_wr;
         sram_wdata_en = usr_wr;
         sram_oe       = usr_rd;
      end
      if (cpu_chk)             cpu_rdata = status_word;
      else if (run && cpu_rd)  cpu_rdata = sram_rdata;
      else                     cpu_rdata = '0;
   end
endmodule

// File: rtl/hs_user_read.sv
module hs_user_read
   import sram_handoff_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              usr_cmd_valid,
   input  logic [1:0]        usr_cmd_op,
   input  logic [DATA_W-1:0] sram_rdata,
   output logic [DATA_W-1:0] usr_rdata,
   output logic              usr_rvalid
);
   logic take;
   assign take = !run && usr_cmd_valid && (usr_cmd_op == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usr_rdata  <= '0;
         usr_rvalid <= 1'b0;
      end else begin
         usr_rvalid <= take;
         if (take) usr_rdata <= sram_rdata;
      end
   end
endmodule

// File: rtl/sram_handoff_ctrl.sv
module sram_handoff_ctrl
   import sram_handoff_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int READY_BIT = 1,
   parameter logic [ADDR_W-1:0] CHECK_ADDR  = 8'hF0,
   parameter logic [ADDR_W-1:0] RESULT_ADDR = 8'hF4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_cmd_valid,
   input  logic [1:0]        usr_cmd_op,
   input  logic [ADDR_W-1:0] usr_addr,
   input  logic [DATA_W-1:0] usr_wdata,
   output logic [DATA_W-1:0] usr_rdata,
   output logic              usr_rvalid,
   output logic              usr_ready_pulse,
   output logic              usr_done_pulse,
   output logic              run,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata,
   output logic              sram_wdata_en,
   output logic              sram_we,
   output logic              sram_oe,
   input  logic [DATA_W-1:0] sram_rdata
);
   if (READY_BIT >= DATA_W) begin : g_bad_bit
      $error("READY_BIT must lie inside the data word");
   end
   if (CHECK_ADDR == RESULT_ADDR) begin : g_bad_addr
      $error("check and result addresses must differ");
   end

   hs_run_ctrl #(
      .ADDR_W(ADDR_W), .CHECK_ADDR(CHECK_ADDR), .RESULT_ADDR(RESULT_ADDR)
   ) u_run (
      .clk(clk), .rst_n(rst_n),
      .usr_cmd_valid(usr_cmd_valid), .usr_cmd_op(usr_cmd_op),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .run(run), .ready_pulse(usr_ready_pulse), .done_pulse(usr_done_pulse)
   );

   hs_port_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READY_BIT(READY_BIT), .CHECK_ADDR(CHECK_ADDR)
   ) u_mux (
      .run(run), .usr_cmd_valid(usr_cmd_valid), .usr_cmd_op(usr_cmd_op),
      .usr_addr(usr_addr), .usr_wdata(usr_wdata),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_wdata_en(sram_wdata_en),
      .sram_we(sram_we), .sram_oe(sram_oe), .sram_rdata(sram_rdata)
   );

   hs_user_read #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .run(run),
      .usr_cmd_valid(usr_cmd_valid), .usr_cmd_op(usr_cmd_op),
      .sram_rdata(sram_rdata), .usr_rdata(usr_rdata), .usr_rvalid(usr_rvalid)
   );
endmodule

// File: rtl/sram_handoff_checker.sv
module sram_handoff_checker #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int READY_BIT = 1,
   parameter logic [ADDR_W-1:0] CHECK_ADDR  = 8'hF0,
   parameter logic [ADDR_W-1:0] RESULT_ADDR = 8'hF4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              usr_cmd_valid,
   input logic [1:0]        usr_cmd_op,
   input logic              usr_rvalid,
   input logic              usr_ready_pulse,
   input logic              usr_done_pulse,
   input logic              run,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              sram_we,
   input logic              sram_wdata_en
);
   logic cpu_poll, cpu_result_wr;
   assign cpu_poll      = cpu_req && !cpu_we && (cpu_addr == CHECK_ADDR);
   assign cpu_result_wr = cpu_req && cpu_we && (cpu_addr == RESULT_ADDR);

   p_poll_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && cpu_poll) |-> (cpu_rdata == '0));
   p_poll_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cpu_poll) |-> (cpu_rdata == (DATA_W'(1) << READY_BIT)));
   p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_cmd_valid && usr_cmd_op == 2'd2) |=> run);
   p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_cmd_valid && usr_cmd_op == 2'd3) |=> !run);
   p_cpu_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(usr_cmd_valid && usr_cmd_op == 2'd0)) |-> (!sram_we && !sram_wdata_en));
   p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      usr_ready_pulse |=> !usr_ready_pulse);
   p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cpu_result_wr) |=> usr_done_pulse);
   p_user_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(cpu_req && cpu_we)) |-> !sram_we);
   p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> !usr_rvalid);
endmodule

bind sram_handoff_ctrl sram_handoff_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READY_BIT(READY_BIT),
   .CHECK_ADDR(CHECK_ADDR), .RESULT_ADDR(RESULT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .usr_cmd_valid(usr_cmd_valid), .usr_cmd_op(usr_cmd_op),
   .usr_rvalid(usr_rvalid), .usr_ready_pulse(usr_ready_pulse),
   .usr_done_pulse(usr_done_pulse), .run(run), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .sram_we(sram_we),
   .sram_wdata_en(sram_wdata_en)
);

// File: tb/tb_sram_handoff_ctrl.sv
module tb_sram_handoff_ctrl;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [AW-1:0] CHK = 8'hF0;
   localparam logic [AW-1:0] RES = 8'hF4;

   logic clk = 0;
   logic rst_n = 0;
   logic usr_cmd_valid = 0;
   logic [1:0] usr_cmd_op = 0;
   logic [AW-1:0] usr_addr = 0;
   logic [DW-1:0] usr_wdata = 0;
   logic [DW-1:0] usr_rdata;
   logic usr_rvalid, usr_ready_pulse, usr_done_pulse, run;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = 0;
   logic [DW-1:0] cpu_wdata = 0;
   logic [DW-1:0] cpu_rdata;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_wdata;
   logic sram_wdata_en, sram_we, sram_oe;
   logic [DW-1:0] sram_rdata;
   logic [DW-1:0] mem [0:(1<<AW)-1];

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   assign sram_rdata = mem[sram_addr];
   always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;

   sram_handoff_ctrl dut (.*);

   function automatic logic [DW-1:0] pat(int a);
      return (32'h9E37_79B9 * (a + 1)) ^ (a << 20);
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      usr_cmd_valid = 0; cpu_req = 0; cpu_we = 0;
   endtask

   task automatic usr_cmd(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      usr_cmd_valid = 1; usr_cmd_op = op; usr_addr = a; usr_wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic usr_read(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
      @(negedge clk);
      usr_cmd_valid = 1; usr_cmd_op = 2'd1; usr_addr = a;
      #1 chk(req, {31'd0, sram_oe}, 32'd1);
      @(negedge clk);
      chk(req, {31'd0, usr_rvalid}, 32'd1);
      chk(req, usr_rdata, exp);
      idle();
   endtask

   task automatic cpu_read(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = a;
      #1 chk(req, cpu_rdata, exp);
   endtask

   initial begin
      for (int a = 0; a < (1<<AW); a++) mem[a] = 32'hDEAD_0000;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      chk("R11", {28'd0, run, usr_ready_pulse, usr_done_pulse, usr_rvalid}, 32'd0);

      // R1 sweep of user writes, with same-cycle strobe check on one write
      @(negedge clk);
      usr_cmd_valid = 1; usr_cmd_op = 2'd0; usr_addr = 8'h3C; usr_wdata = pat(8'h3C);
      #1 chk("R1", {sram_addr, 22'd0, sram_we, sram_wdata_en}, {8'h3C, 22'd0, 2'b11});
      chk("R1", sram_wdata, pat(8'h3C));
      for (int a = 0; a < (1<<AW); a++) begin
         @(negedge clk);
         usr_cmd_valid = 1; usr_cmd_op = 2'd0; usr_addr = AW'(a); usr_wdata = pat(a);
      end
      @(negedge clk); idle();
      // R2 read sweep
      for (int a = 0; a < (1<<AW); a++) usr_read(AW'(a), pat(a), "R2");
      @(negedge clk);
      chk("R2", {31'd0, usr_rvalid}, 32'd0);

      // R3 poll while stopped; R8 first poll raises ready
      cpu_read(CHK, 32'd0, "R3");
      @(negedge clk);
      chk("R8", {31'd0, usr_ready_pulse}, 32'd1);
      @(negedge clk);
      chk("R8", {31'd0, usr_ready_pulse}, 32'd0);
      idle();
      cpu_read(CHK, 32'd0, "R3");
      @(negedge clk);
      chk("R8", {31'd0, usr_ready_pulse}, 32'd0);
      // R7 ordinary cpu read and write while stopped
      cpu_read(8'h10, 32'd0, "R7");
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_addr = 8'h11; cpu_wdata = 32'h1234_5678;
      #1 chk("R7", {30'd0, sram_we, sram_wdata_en}, 32'd0);
      @(negedge clk); idle();
      usr_read(8'h11, pat(8'h11), "R7");

      // R5 start
      usr_cmd(2'd2, 0, 0);
      chk("R5", {31'd0, run}, 32'd1);
      cpu_read(CHK, 32'd2, "R4");
      cpu_read(8'h22, pat(8'h22), "R5");
      cpu_read(8'h80, pat(8'h80), "R5");
      @(negedge clk);
      chk("R8", {31'd0, usr_ready_pulse}, 32'd0);
      // R9 result write
      cpu_req = 1; cpu_we = 1; cpu_addr = RES; cpu_wdata = 32'h0000_000B;
      @(negedge clk);
      chk("R9", {31'd0, usr_done_pulse}, 32'd1);
      idle();
      @(negedge clk);
      chk("R9", {31'd0, usr_done_pulse}, 32'd0);
      // R5 ordinary cpu write
      cpu_req = 1; cpu_we = 1; cpu_addr = 8'h30; cpu_wdata = 32'hCAFE_F00D;
      @(negedge clk);
      chk("R9", {31'd0, usr_done_pulse}, 32'd0);
      idle();
      // R10 user write and read while running
      @(negedge clk);
      usr_cmd_valid = 1; usr_cmd_op = 2'd0; usr_addr = 8'h40; usr_wdata = 32'hBAD0_BAD0;
      #1 chk("R10", {31'd0, sram_we}, 32'd0);
      @(negedge clk);
      usr_cmd_op = 2'd1;
      @(negedge clk);
      chk("R10", {31'd0, usr_rvalid}, 32'd0);
      idle();

      // R6 halt
      usr_cmd(2'd3, 0, 0);
      chk("R6", {31'd0, run}, 32'd0);
      usr_read(RES, 32'h0000_000B, "R9");
      usr_read(8'h30, 32'hCAFE_F00D, "R5");
      usr_read(8'h40, pat(8'h40), "R10");
      cpu_read(CHK, 32'd0, "R6");
      @(negedge clk);
      chk("R8", {31'd0, usr_ready_pulse}, 32'd1);
      idle();
      // second run cycle
      usr_cmd(2'd2, 0, 0);
      cpu_read(CHK, 32'd2, "R4");
      @(negedge clk);
      chk("R8", {31'd0, usr_ready_pulse}, 32'd0);
      idle();
      usr_cmd(2'd3, 0, 0);
      chk("R6", {31'd0, run}, 32'd0);
      usr_cmd(2'd0, 8'h41, 32'h0F0F_0F0F);
      usr_read(8'h41, 32'h0F0F_0F0F, "R6");

      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule